// File: doc/BRIEF.md
# Deterministic Token Quantum Arbiter

This block makes memory access among a group of processor cores repeat identically from run to run. One token circulates among the cores. Only the core that holds it is granted memory access, and every other core that asks for memory is stalled. The holder keeps the token for one quantum, which is a programmable count of its own retired instructions. When that quantum completes, the token moves to the next core in ascending index order and wraps from the last core back to core 0.

Quanta are bounded only by architectural events, so the interleaving does not depend on caches or pipeline timing. The events are retirements, unlocks and the halting of a core. An unlock retired by the holder closes its quantum at once, so a core waiting on that lock gets the token sooner. Halted cores are skipped during rotation. A new quantum length can be presented on the configuration input at any time, but it is only adopted when a quantum closes.

Top module: `det_token_arbiter`

## Requirements
- R1: While reset is asserted and after it is released, the token is held by core 0, the retire count is zero, and the active quantum length equals the `DEF_QUANTUM` parameter.
- R2: `grant[i]` is 1 only when core i requests memory, holds the token and is not halted. `stall[i]` is 1 exactly when core i requests memory and is not granted. With no request, both are 0.
- R3: Each retire pulse from the holder adds one to the quantum count. The quantum ends on the clock edge where the holder's retire brings the count to the active length. On the next cycle the owner is the next core in ascending order, with wrap-around.
- R4: Retire pulses from cores that do not hold the token have no effect on the quantum count.
- R5: An unlock pulse from the holder ends the quantum on that clock edge, whatever the count is. Unlock pulses from other cores are ignored.
- R6: During rotation, cores whose `halted` bit is set are skipped in the same cycle. If every other core is halted, the token returns to the current holder, provided that holder is not halted.
- R7: If the holder's own `halted` bit is set, its quantum ends on that edge and the token moves on.
- R8: A halted core is never granted.
- R9: `quantum_len` is sampled only on the edge that closes a quantum. Changing it in the middle of a quantum does not alter the length of the quantum in progress.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| quantum_len | input | QW | Quantum length to adopt at the next boundary |
| retire | input | NCORES | Per-core retired-instruction pulse |
| unlock | input | NCORES | Per-core retired-unlock pulse |
| mem_req | input | NCORES | Per-core memory request |
| halted | input | NCORES | Per-core halted flag |
| grant | output | NCORES | Per-core memory grant |
| stall | output | NCORES | Per-core stall (request without grant) |
| token_owner | output | IW | Index of the core holding the token |

## Verification
The hardest case to reach is a boundary where the usual successor cannot take the token. This covers the holder halting, a skip across several halted cores, and the case where every other core is halted and the token must come back to the holder. The stimulus table reaches these by holding specific `halted` patterns while the holder retires an unlock. A directed sequence also changes `quantum_len` in the middle of a quantum and counts the retires before the owner moves, which shows that the new length starts only at the boundary.

// File: rtl/det_token_arbiter.sv
module det_token_arbiter #(
  parameter int NCORES      = 4,
  parameter int QW          = 16,
  parameter int DEF_QUANTUM = 1000,
  localparam int IW         = (NCORES > 1) ? $clog2(NCORES) : 1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [QW-1:0]     quantum_len,
  input  logic [NCORES-1:0] retire,
  input  logic [NCORES-1:0] unlock,
  input  logic [NCORES-1:0] mem_req,
  input  logic [NCORES-1:0] halted,
  output logic [NCORES-1:0] grant,
  output logic [NCORES-1:0] stall,
  output logic [IW-1:0]     token_owner
);

  logic [IW-1:0] owner_q, owner_nx;
  logic [QW-1:0] cnt_q, len_q;
  logic          own_ret, own_unl, own_hlt, qend;

  assign own_ret = retire[owner_q];
  assign own_unl = unlock[owner_q];
  assign own_hlt = halted[owner_q];
  assign qend    = own_unl | own_hlt |
                   (own_ret && (({1'b0, cnt_q} + (QW+1)'(1)) >= {1'b0, len_q}));

  always_comb begin
    logic          found;
    logic [IW:0]   idx;
    owner_nx = owner_q;
    found    = 1'b0;
    for (int k = 1; k <= NCORES; k++) begin
      idx = {1'b0, owner_q} + (IW+1)'(k);
      if (idx >= (IW+1)'(NCORES)) idx = idx - (IW+1)'(NCORES);
      if (!found && !halted[idx[IW-1:0]]) begin
        owner_nx = idx[IW-1:0];
        found    = 1'b1;
      end
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      owner_q <= '0;
      cnt_q   <= '0;
      len_q   <= QW'(DEF_QUANTUM);
    end else if (qend) begin
      owner_q <= owner_nx;
      cnt_q   <= '0;
      len_q   <= quantum_len;
    end else if (own_ret) begin
      cnt_q   <= cnt_q + QW'(1);
    end
  end

  for (genvar i = 0; i < NCORES; i++) begin : g_port
    assign grant[i] = mem_req[i] & ~halted[i] & (owner_q == IW'(i));
    assign stall[i] = mem_req[i] & ~grant[i];
  end

  assign token_owner = owner_q;

endmodule

// File: rtl/det_token_arbiter_sva.sv
module det_token_arbiter_sva #(
  parameter int NCORES = 4,
  parameter int QW     = 16,
  parameter int IW     = 2
) (
  input logic              clk,
  input logic              rst_n,
  input logic [NCORES-1:0] retire,
  input logic [NCORES-1:0] unlock,
  input logic [NCORES-1:0] mem_req,
  input logic [NCORES-1:0] halted,
  input logic [NCORES-1:0] grant,
  input logic [NCORES-1:0] stall,
  input logic [IW-1:0]     token_owner,
  input logic [QW-1:0]     cnt_q,
  input logic [QW-1:0]     len_q
);

  logic [NCORES-1:0] others_live;
  always_comb begin
    for (int i = 0; i < NCORES; i++)
      others_live[i] = ~halted[i] & (token_owner != IW'(i));
  end

  a_r1_reset_owner: assert property (@(posedge clk) !rst_n |=> token_owner == '0);

  a_r2_single_grant: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(grant));

  a_r2_grant_needs_req: assert property (@(posedge clk) disable iff (!rst_n)
    (grant & ~mem_req) == '0);

  a_r2_stall_excl: assert property (@(posedge clk) disable iff (!rst_n)
    (grant & stall) == '0);

  a_r3_count_bound: assert property (@(posedge clk) disable iff (!rst_n)
    cnt_q == '0 || cnt_q < len_q);

  a_r3_owner_holds: assert property (@(posedge clk) disable iff (!rst_n)
    (!retire[token_owner] && !unlock[token_owner] && !halted[token_owner])
      |=> $stable(token_owner));

  a_r5_unlock_moves: assert property (@(posedge clk) disable iff (!rst_n)
    (unlock[token_owner] && |others_live) |=> token_owner != $past(token_owner));

  a_r8_halted_no_grant: assert property (@(posedge clk) disable iff (!rst_n)
    (grant & halted) == '0);

endmodule

bind det_token_arbiter det_token_arbiter_sva #(.NCORES(NCORES), .QW(QW), .IW(IW)) u_sva (
  .clk(clk), .rst_n(rst_n), .retire(retire), .unlock(unlock), .mem_req(mem_req),
  .halted(halted), .grant(grant), .stall(stall), .token_owner(token_owner),
  .cnt_q(cnt_q), .len_q(len_q)
);

// File: tb/det_token_arbiter_bench.sv
module det_token_arbiter_bench;
  localparam int CLK_PERIOD = 10;
  localparam int N  = 4;
  localparam int QW = 8;
  localparam int DQ = 4;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic [QW-1:0] quantum_len = QW'(DQ);
  logic [N-1:0]  retire = '0, unlock = '0, mem_req = '0, halted = '0;
  logic [N-1:0]  grant, stall;
  logic [1:0]    token_owner;

  int checks = 0;
  int fails  = 0;
  bit done   = 0;

  det_token_arbiter #(.NCORES(N), .QW(QW), .DEF_QUANTUM(DQ)) u_det_token_arbiter (
    .clk(clk), .rst_n(rst_n), .quantum_len(quantum_len), .retire(retire),
    .unlock(unlock), .mem_req(mem_req), .halted(halted), .grant(grant),
    .stall(stall), .token_owner(token_owner)
  );

  always #(CLK_PERIOD/2) clk = ~clk;

  // {retire, unlock, mem_req, halted, exp_grant, exp_stall, exp_owner_after_edge}
  localparam logic [25:0] VEC [14] = '{
    {4'b0000, 4'b0000, 4'b1111, 4'b0000, 4'b0001, 4'b1110, 2'd0}, // R2
    {4'b0001, 4'b0000, 4'b0010, 4'b0000, 4'b0000, 4'b0010, 2'd0}, // R3 count 1
    {4'b1110, 4'b0000, 4'b0000, 4'b0000, 4'b0000, 4'b0000, 2'd0}, // R4
    {4'b0001, 4'b0000, 4'b0000, 4'b0000, 4'b0000, 4'b0000, 2'd0}, // R3 count 2
    {4'b0001, 4'b0000, 4'b0000, 4'b0000, 4'b0000, 4'b0000, 2'd0}, // R3 count 3
    {4'b0001, 4'b0000, 4'b0001, 4'b0000, 4'b0001, 4'b0000, 2'd1}, // R3 boundary
    {4'b0000, 4'b0001, 4'b0010, 4'b0000, 4'b0010, 4'b0000, 2'd1}, // R5 foreign unlock
    {4'b0000, 4'b0010, 4'b0000, 4'b0000, 4'b0000, 4'b0000, 2'd2}, // R5 holder unlock
    {4'b0000, 4'b0100, 4'b1000, 4'b1000, 4'b0000, 4'b1000, 2'd0}, // R6 skip 3, R8
    {4'b0000, 4'b0000, 4'b0001, 4'b0001, 4'b0000, 4'b0001, 2'd1}, // R7, R8
    {4'b0000, 4'b0000, 4'b0000, 4'b0110, 4'b0000, 4'b0000, 2'd3}, // R7 + R6
    {4'b0000, 4'b1000, 4'b1000, 4'b0111, 4'b1000, 4'b0000, 2'd3}, // R6 return to holder
    {4'b1000, 4'b0000, 4'b0000, 4'b0000, 4'b0000, 4'b0000, 2'd3}, // R3 count 1
    {4'b1000, 4'b1000, 4'b0000, 4'b0000, 4'b0000, 4'b0000, 2'd0}  // R3/R5 wrap
  };

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic finish_up;
    if (!done) begin
      done = 1;
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  endtask

  task automatic step(input logic [N-1:0] r, input logic [N-1:0] u,
                      input logic [N-1:0] q, input logic [N-1:0] h);
    @(negedge clk);
    retire = r; unlock = u; mem_req = q; halted = h;
  endtask

  task automatic do_reset;
    @(negedge clk);
    rst_n = 1'b0; retire = '0; unlock = '0; mem_req = '0; halted = '0;
    @(negedge clk);
    @(negedge clk);
    rst_n = 1'b1;
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    fails++;
    $display("FAIL watchdog: actual timeout expected completion");
    finish_up();
  end

  initial begin
    do_reset();
    #1;
    check("R1 owner after reset", 32'(token_owner), 0);
    check("R1 no grant idle", 32'(grant), 0);

    for (int v = 0; v < 14; v++) begin
      step(VEC[v][25:22], VEC[v][21:18], VEC[v][17:14], VEC[v][13:10]);
      #1;
      check($sformatf("R2 grant vec %0d", v), 32'(grant), 32'(VEC[v][9:6]));
      check($sformatf("R2 stall vec %0d", v), 32'(stall), 32'(VEC[v][5:2]));
      @(posedge clk);
      #1;
      check($sformatf("R3 owner vec %0d", v), 32'(token_owner), 32'(VEC[v][1:0]));
    end

    // R1: mid-run reset restores core 0 and the default length (4), even with quantum_len=2
    quantum_len = QW'(2);
    step(4'b0000, 4'b0000, 4'b0000, 4'b0000);
    step(4'b0000, 4'b0010, 4'b0000, 4'b0000);
    do_reset();
    #1;
    check("R1 owner after second reset", 32'(token_owner), 0);

    // R9: len 2 presented, but first quantum still needs 4 retires
    for (int k = 1; k <= 3; k++) begin
      step(4'b0001, 4'b0000, 4'b0000, 4'b0000);
      @(posedge clk); #1;
      check($sformatf("R9 old length holds, retire %0d", k), 32'(token_owner), 0);
    end
    step(4'b0001, 4'b0000, 4'b0000, 4'b0000);
    @(posedge clk); #1;
    check("R9 boundary at old length", 32'(token_owner), 1);
    step(4'b0010, 4'b0000, 4'b0000, 4'b0000);
    @(posedge clk); #1;
    check("R9 new length first retire", 32'(token_owner), 1);
    step(4'b0010, 4'b0000, 4'b0000, 4'b0000);
    @(posedge clk); #1;
    check("R9 new length applied", 32'(token_owner), 2);

    // R4: retires from non-holders over many cycles never move the token
    for (int k = 0; k < 6; k++) step(4'b1011, 4'b0000, 4'b0000, 4'b0000);
    @(posedge clk); #1;
    check("R4 foreign retires ignored", 32'(token_owner), 2);

    step(4'b0000, 4'b0000, 4'b0000, 4'b0000);
    @(negedge clk);
    finish_up();
  end
endmodule